// File: doc/BRIEF.md
# Full-Map Coherence Home Directory

This block is the home node of a small shared-memory system. It keeps a coherence record for every memory block it owns, and it holds the backing copy of each block's data. Each record has a state (Uncached, Shared or Modified) and a sharer bit vector with one bit per core. When a block is Modified, the single set bit names its owner, so no separate owner field is kept.

Cores send read and write requests on per-core valid/ready lanes. Each cycle, a fixed-priority arbiter accepts at most one request, and the lowest-numbered core wins. Accepted requests enter a FIFO and are served strictly one at a time, in the order they were accepted. The directory answers on one valid/ready outbound port with data replies, invalidates, invalidate-forwards, forward-reads and write grants. An outbound message stays on the port unchanged until the port accepts it, so downstream back-pressure stalls the whole engine. Invalidate acknowledgements and owner write-backs arrive on separate inputs that are always accepted and have no ready signal.

A write to a Shared block invalidates every other sharer, one message per accepted cycle. The directory counts acknowledgements against the number of invalidates it sent before it grants the write. A writer that already holds a shared copy is upgraded without a data payload. Racing writers are ordered by the arbiter and the FIFO, so the writer served last ends as owner.

Top module: `coh_dir_home`

## Requirements
- R1: After reset every block is Uncached with an empty sharer vector, and block b holds the memory value (32 + 3·b) mod 2^DW. Uncached always has an empty vector, Modified always has exactly one bit set, and no output message is valid during reset.
- R2: A read to an Uncached block returns a data reply (out_kind 0, has_data 1) to the requester with the stored memory value. The block becomes Shared with only the requester's bit set.
- R3: A read to a Shared block returns a data reply from memory and adds the requester's bit. No invalidate is sent.
- R4: A read to a Modified block sends a forward-read (out_kind 3) to the owner. The directory then waits for that owner's write-back for the block, stores the written-back value in memory, and moves the block to Shared with exactly the requester and the old owner set. Later reads are served with the repaired value.
- R5: A write to a Shared block sends an invalidate (out_kind 1) to each other sharer in ascending core order. The write grant (out_kind 4) is issued only after the number of acknowledgements counted equals the number of invalidates sent. The block then becomes Modified with only the requester's bit set. Memory is not changed by the grant.
- R6: A writer that is already a sharer is never invalidated, and its grant has has_data 0. A writer with no copy (of a Shared or an Uncached block) receives a grant with has_data 1 and the memory value.
- R7: A write to a block Modified by another core sends an invalidate-forward (out_kind 2) to the owner. After one acknowledgement, the requester gets a grant with has_data 0 and becomes the sole owner.
- R8: A write from the current Modified owner is granted at once (has_data 0), and the block's state and owner are left unchanged.
- R9: Among requests valid in the same cycle, only the lowest-numbered core sees req_ready. At most one ready bit is high, and ready is never high without valid.
- R10: Requests are served strictly in acceptance order, and none is dequeued while a transaction is pending. Two writers racing on a Shared block are both granted, in turn, and the later one ends as owner through an invalidate-forward to the earlier one.
- R11: While out_valid is high and out_ready is low, every outbound field holds its value. Every message carries the serviced requester in out_requester, and out_data is 0 when has_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NCORES | Per-core request valid |
| req_write | input | NCORES | Per-core request kind: 1 write, 0 read |
| req_blk | input | NCORES*BW | Per-core block index, core i in bits [i*BW +: BW] |
| req_ready | output | NCORES | Per-core request accepted this cycle |
| out_valid | output | 1 | Outbound message valid |
| out_ready | input | 1 | Outbound message accepted |
| out_kind | output | 3 | 0 data reply, 1 invalidate, 2 invalidate-forward, 3 forward-read, 4 write grant |
| out_dest | output | CW | Destination core |
| out_blk | output | BW | Block index |
| out_data | output | DW | Payload, 0 when no payload |
| out_has_data | output | 1 | Payload present |
| out_requester | output | CW | Core whose request the message serves |
| ack_valid | input | 1 | Invalidate acknowledgement strobe |
| ack_core | input | CW | Acknowledging core |
| ack_blk | input | BW | Acknowledged block |
| wb_valid | input | 1 | Write-back strobe |
| wb_core | input | CW | Core writing back |
| wb_blk | input | BW | Written-back block |
| wb_data | input | DW | Written-back data |

## Verification
On every cycle, the assertions check the record invariants: Modified has one owner and Uncached has no sharers. They also check that the acknowledgement count never passes the number of invalidates sent, that no invalidate targets the requester, that arbitration is one-hot and needs valid, that the FIFO never overflows, and that outbound messages stay stable under back-pressure. Only the bench's scenarios can show the protocol outcomes. These include which messages each state and operation produce and in what order, that a grant waits for delayed acknowledgements, that memory is repaired only through write-back, and that racing writers end with the later one as owner.

// File: rtl/cdir_pkg.sv
package cdir_pkg;

  typedef enum logic [1:0] {
    BLK_UNC = 2'd0,
    BLK_SHR = 2'd1,
    BLK_MOD = 2'd2
  } blk_state_e;

  typedef enum logic [2:0] {
    MSG_DATA   = 3'd0,
    MSG_INV    = 3'd1,
    MSG_INVFWD = 3'd2,
    MSG_FWDRD  = 3'd3,
    MSG_WACK   = 3'd4
  } msg_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_INV  = 2'd1,
    PH_ACKW = 2'd2,
    PH_WBW  = 2'd3
  } phase_e;

endpackage

// File: rtl/cdir_req_arb.sv
module cdir_req_arb #(
  parameter int NCORES = 4,
  parameter int BW     = 3,
  parameter int CW     = $clog2(NCORES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCORES-1:0]    valid,
  input  logic [NCORES-1:0]    write,
  input  logic [NCORES*BW-1:0] blk,
  input  logic                 full,
  output logic [NCORES-1:0]    ready,
  output logic                 push,
  output logic [CW-1:0]        p_core,
  output logic                 p_write,
  output logic [BW-1:0]        p_blk
);

  logic [BW-1:0] blk_arr [NCORES];
  logic          found;
  logic [CW-1:0] sel;

  genvar g;
  generate
    for (g = 0; g < NCORES; g++) begin : g_unpack
      assign blk_arr[g] = blk[g*BW +: BW];
    end
  endgenerate

  // fixed priority: lowest core index wins
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = NCORES - 1; i >= 0; i--) begin
      if (valid[i]) begin
        found = 1'b1;
        sel   = CW'(i);
      end
    end
  end

  always_comb begin
    ready = '0;
    if (found && !full) ready[sel] = 1'b1;
  end

  assign push    = found && !full;
  assign p_core  = sel;
  assign p_write = write[sel];
  assign p_blk   = blk_arr[sel];

  AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ready)); // R9
  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (ready & ~valid) == '0); // R9

endmodule

// File: rtl/cdir_fifo.sv
module cdir_fifo #(
  parameter int WIDTH = 6,
  parameter int DEPTH = 4,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CNTW-1:0]  cnt;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt == '0);
  assign full  = (cnt == CNTW'(DEPTH));
  assign dout  = store[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else begin
      if (push) begin
        store[wp] <= din;
        wp        <= nxt(wp);
      end
      if (pop) rp <= nxt(rp);
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop)); // R10
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R10

endmodule

// File: rtl/cdir_engine.sv
module cdir_engine
  import cdir_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int NBLK   = 8,
  parameter int DW     = 8,
  parameter int CW     = $clog2(NCORES),
  parameter int BW     = $clog2(NBLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_avail,
  input  logic [CW-1:0] h_core,
  input  logic          h_write,
  input  logic [BW-1:0] h_blk,
  output logic          pop,
  output logic          o_valid,
  input  logic          out_ready,
  output msg_kind_e     o_kind,
  output logic [CW-1:0] o_dest,
  output logic [BW-1:0] o_blk,
  output logic [DW-1:0] o_data,
  output logic          o_hasd,
  output logic [CW-1:0] o_req,
  input  logic          ack_valid,
  input  logic [CW-1:0] ack_core,
  input  logic [BW-1:0] ack_blk,
  input  logic          wb_valid,
  input  logic [CW-1:0] wb_core,
  input  logic [BW-1:0] wb_blk,
  input  logic [DW-1:0] wb_data
);

  blk_state_e        st  [NBLK];
  logic [NCORES-1:0] vec [NBLK];
  logic [DW-1:0]     mem [NBLK];

  phase_e            ph;
  logic [CW-1:0]     cur_core, own_core;
  logic [BW-1:0]     cur_blk;
  logic [NCORES-1:0] inv_left;
  logic [CW:0]       inv_need, ack_got;
  logic              wack_hasd;

  function automatic logic [CW-1:0] low_idx(input logic [NCORES-1:0] v);
    logic [CW-1:0] r;
    r = '0;
    for (int i = NCORES - 1; i >= 0; i--) if (v[i]) r = CW'(i);
    return r;
  endfunction

  function automatic logic [CW:0] popcnt(input logic [NCORES-1:0] v);
    logic [CW:0] c;
    c = '0;
    for (int i = 0; i < NCORES; i++) c = c + (CW+1)'(v[i]);
    return c;
  endfunction

  function automatic logic [NCORES-1:0] bit_of(input logic [CW-1:0] c);
    return NCORES'(1) << c;
  endfunction

  logic              o_free, ack_hit;
  blk_state_e        hs;
  logic [NCORES-1:0] hv, hmask, hoth;
  logic [CW-1:0]     howner, inv_tgt;

  assign o_free  = !o_valid || out_ready;
  assign pop     = (ph == PH_IDLE) && o_free && h_avail;
  assign hs      = st[h_blk];
  assign hv      = vec[h_blk];
  assign hmask   = bit_of(h_core);
  assign hoth    = hv & ~hmask;
  assign howner  = low_idx(hv);
  assign inv_tgt = low_idx(inv_left);
  assign ack_hit = ack_valid && (ack_blk == cur_blk) && (ack_core != cur_core)
                   && ((ph == PH_INV) || (ph == PH_ACKW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBLK; b++) begin
        st[b]  <= BLK_UNC;
        vec[b] <= '0;
        mem[b] <= DW'(32 + 3 * b);
      end
      ph        <= PH_IDLE;
      cur_core  <= '0;
      own_core  <= '0;
      cur_blk   <= '0;
      inv_left  <= '0;
      inv_need  <= '0;
      ack_got   <= '0;
      wack_hasd <= 1'b0;
      o_valid   <= 1'b0;
      o_kind    <= MSG_DATA;
      o_dest    <= '0;
      o_blk     <= '0;
      o_data    <= '0;
      o_hasd    <= 1'b0;
      o_req     <= '0;
    end else begin
      if (o_valid && out_ready) o_valid <= 1'b0;
      if (wb_valid) mem[wb_blk] <= wb_data;
      if (ack_hit) ack_got <= ack_got + 1'b1;

      unique case (ph)
        PH_IDLE: begin
          if (pop) begin
            cur_core <= h_core;
            cur_blk  <= h_blk;
            o_valid  <= 1'b1;
            o_blk    <= h_blk;
            o_req    <= h_core;
            o_dest   <= h_core;
            o_data   <= '0;
            o_hasd   <= 1'b0;
            o_kind   <= MSG_WACK;
            if (!h_write) begin
              if (hs == BLK_MOD) begin
                o_kind   <= MSG_FWDRD;
                o_dest   <= howner;
                own_core <= howner;
                ph       <= PH_WBW;
              end else begin
                o_kind       <= MSG_DATA;
                o_data       <= mem[h_blk];
                o_hasd       <= 1'b1;
                st[h_blk]    <= BLK_SHR;
                vec[h_blk]   <= hv | hmask;
              end
            end else begin
              unique case (hs)
                BLK_UNC: begin
                  o_data     <= mem[h_blk];
                  o_hasd     <= 1'b1;
                  st[h_blk]  <= BLK_MOD;
                  vec[h_blk] <= hmask;
                end
                BLK_SHR: begin
                  if (hoth == '0) begin
                    st[h_blk]  <= BLK_MOD;
                    vec[h_blk] <= hmask;
                  end else begin
                    o_valid   <= 1'b0;
                    inv_left  <= hoth;
                    inv_need  <= popcnt(hoth);
                    ack_got   <= '0;
                    wack_hasd <= !hv[h_core];
                    ph        <= PH_INV;
                  end
                end
                default: begin
                  if (howner != h_core) begin
                    o_kind    <= MSG_INVFWD;
                    o_dest    <= howner;
                    inv_need  <= (CW+1)'(1);
                    ack_got   <= '0;
                    wack_hasd <= 1'b0;
                    ph        <= PH_ACKW;
                  end
                end
              endcase
            end
          end
        end

        PH_INV: begin
          if (o_free) begin
            o_valid  <= 1'b1;
            o_kind   <= MSG_INV;
            o_dest   <= inv_tgt;
            o_blk    <= cur_blk;
            o_req    <= cur_core;
            o_data   <= '0;
            o_hasd   <= 1'b0;
            inv_left <= inv_left & ~bit_of(inv_tgt);
            if ((inv_left & ~bit_of(inv_tgt)) == '0) ph <= PH_ACKW;
          end
        end

        PH_ACKW: begin
          if (o_free && (ack_got == inv_need)) begin
            o_valid      <= 1'b1;
            o_kind       <= MSG_WACK;
            o_dest       <= cur_core;
            o_blk        <= cur_blk;
            o_req        <= cur_core;
            o_hasd       <= wack_hasd;
            o_data       <= wack_hasd ? mem[cur_blk] : '0;
            st[cur_blk]  <= BLK_MOD;
            vec[cur_blk] <= bit_of(cur_core);
            ph           <= PH_IDLE;
          end
        end

        PH_WBW: begin
          if (wb_valid && (wb_blk == cur_blk) && (wb_core == own_core)) begin
            st[cur_blk]  <= BLK_SHR;
            vec[cur_blk] <= bit_of(cur_core) | bit_of(own_core);
            ph           <= PH_IDLE;
          end
        end

        default: ph <= PH_IDLE;
      endcase
    end
  end

  genvar gb;
  generate
    for (gb = 0; gb < NBLK; gb++) begin : g_inv
      AST_MOD_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (st[gb] == BLK_MOD) |-> $onehot(vec[gb])); // R1
      AST_UNC_NO_SHARER: assert property (@(posedge clk) disable iff (!rst_n)
        (st[gb] == BLK_UNC) |-> (vec[gb] == '0)); // R1
    end
  endgenerate

  AST_ACK_WITHIN_SENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph == PH_INV) || (ph == PH_ACKW)) |-> (ack_got <= inv_need)); // R5
  AST_INV_NOT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && (o_kind == MSG_INV)) |-> (o_dest != o_req)); // R6

endmodule

// File: rtl/coh_dir_home.sv
module coh_dir_home
  import cdir_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int NBLK   = 8,
  parameter int DW     = 8,
  parameter int QDEPTH = 4,
  parameter int CW     = $clog2(NCORES),
  parameter int BW     = $clog2(NBLK)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCORES-1:0]    req_valid,
  input  logic [NCORES-1:0]    req_write,
  input  logic [NCORES*BW-1:0] req_blk,
  output logic [NCORES-1:0]    req_ready,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [2:0]           out_kind,
  output logic [CW-1:0]        out_dest,
  output logic [BW-1:0]        out_blk,
  output logic [DW-1:0]        out_data,
  output logic                 out_has_data,
  output logic [CW-1:0]        out_requester,
  input  logic                 ack_valid,
  input  logic [CW-1:0]        ack_core,
  input  logic [BW-1:0]        ack_blk,
  input  logic                 wb_valid,
  input  logic [CW-1:0]        wb_core,
  input  logic [BW-1:0]        wb_blk,
  input  logic [DW-1:0]        wb_data
);

  localparam int QW = CW + 1 + BW;

  logic          push, full, empty, pop;
  logic [CW-1:0] p_core;
  logic          p_write;
  logic [BW-1:0] p_blk;
  logic [QW-1:0] q_out;
  msg_kind_e     kind;

  cdir_req_arb #(.NCORES(NCORES), .BW(BW), .CW(CW)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (req_valid),
    .write   (req_write),
    .blk     (req_blk),
    .full    (full),
    .ready   (req_ready),
    .push    (push),
    .p_core  (p_core),
    .p_write (p_write),
    .p_blk   (p_blk)
  );

  cdir_fifo #(.WIDTH(QW), .DEPTH(QDEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .din   ({p_core, p_write, p_blk}),
    .pop   (pop),
    .dout  (q_out),
    .empty (empty),
    .full  (full)
  );

  cdir_engine #(.NCORES(NCORES), .NBLK(NBLK), .DW(DW), .CW(CW), .BW(BW)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .h_avail   (!empty),
    .h_core    (q_out[QW-1 -: CW]),
    .h_write   (q_out[BW]),
    .h_blk     (q_out[BW-1:0]),
    .pop       (pop),
    .o_valid   (out_valid),
    .out_ready (out_ready),
    .o_kind    (kind),
    .o_dest    (out_dest),
    .o_blk     (out_blk),
    .o_data    (out_data),
    .o_hasd    (out_has_data),
    .o_req     (out_requester),
    .ack_valid (ack_valid),
    .ack_core  (ack_core),
    .ack_blk   (ack_blk),
    .wb_valid  (wb_valid),
    .wb_core   (wb_core),
    .wb_blk    (wb_blk),
    .wb_data   (wb_data)
  );

  assign out_kind = kind;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_dest)
      && $stable(out_blk) && $stable(out_data) && $stable(out_has_data)
      && $stable(out_requester))); // R11
  AST_NO_PAYLOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_has_data) |-> (out_data == '0)); // R11

endmodule

// File: tb/coh_dir_home_bench.sv
module coh_dir_home_bench;
  localparam int N = 4, NB = 8, DW = 8, CW = 2, BW = 3;
  localparam logic [2:0] K_DATA = 3'd0, K_INV = 3'd1, K_IFWD = 3'd2, K_FRD = 3'd3, K_WACK = 3'd4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic [N-1:0] req_valid, req_write, req_ready;
  logic [N*BW-1:0] req_blk;
  logic out_valid, out_ready, out_has_data;
  logic [2:0] out_kind;
  logic [CW-1:0] out_dest, out_requester, ack_core, wb_core;
  logic [BW-1:0] out_blk, ack_blk, wb_blk;
  logic [DW-1:0] out_data, wb_data;
  logic ack_valid, wb_valid;

  coh_dir_home u_coh_dir_home (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_blk(req_blk), .req_ready(req_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_kind(out_kind), .out_dest(out_dest),
    .out_blk(out_blk), .out_data(out_data), .out_has_data(out_has_data),
    .out_requester(out_requester), .ack_valid(ack_valid), .ack_core(ack_core),
    .ack_blk(ack_blk), .wb_valid(wb_valid), .wb_core(wb_core), .wb_blk(wb_blk),
    .wb_data(wb_data)
  );

  typedef struct packed {
    logic [2:0] k; logic [CW-1:0] d; logic [BW-1:0] b;
    logic [DW-1:0] dat; logic hd; logic [CW-1:0] rq;
  } msg_t;
  typedef struct {bit isack; logic [CW-1:0] c; logic [BW-1:0] b; int due;} resp_t;

  msg_t exp_q[$];
  string tag_q[$];
  resp_t resp_q[$];
  int n_tests = 0, n_fail = 0;
  bit bp = 1'b0, done = 1'b0;

  logic [1:0] m_st [NB];   // 0 U, 1 S, 2 M
  logic [N-1:0] m_vec [NB];
  logic [DW-1:0] m_mem [NB];

  function automatic logic [DW-1:0] wbval(input logic [BW-1:0] b, input logic [CW-1:0] c);
    return 8'h80 | (DW'(b) << 2) | DW'(c);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  task automatic expect_msg(input logic [2:0] k, input int d, input int b,
                            input logic [DW-1:0] dat, input bit hd, input int rq, input string tag);
    msg_t m;
    m = '{k: k, d: CW'(d), b: BW'(b), dat: dat, hd: hd, rq: CW'(rq)};
    exp_q.push_back(m);
    tag_q.push_back(tag);
  endtask

  // reference model built from the requirements
  task automatic model(input int c, input bit w, input int b, input string tag);
    int own;
    bit hd;
    own = 0;
    for (int i = N - 1; i >= 0; i--) if (m_vec[b][i]) own = i;
    if (!w) begin
      if (m_st[b] != 2) begin
        expect_msg(K_DATA, c, b, m_mem[b], 1'b1, c, tag);
        m_st[b] = 1; m_vec[b][c] = 1'b1;
      end else begin
        expect_msg(K_FRD, own, b, '0, 1'b0, c, tag);
        m_mem[b] = wbval(BW'(b), CW'(own));
        m_st[b] = 1; m_vec[b] = '0; m_vec[b][c] = 1'b1; m_vec[b][own] = 1'b1;
      end
    end else begin
      if (m_st[b] == 0) begin
        expect_msg(K_WACK, c, b, m_mem[b], 1'b1, c, tag);
        m_st[b] = 2; m_vec[b] = '0; m_vec[b][c] = 1'b1;
      end else if (m_st[b] == 1) begin
        for (int i = 0; i < N; i++)
          if (m_vec[b][i] && i != c) expect_msg(K_INV, i, b, '0, 1'b0, c, tag);
        hd = !m_vec[b][c];
        expect_msg(K_WACK, c, b, hd ? m_mem[b] : '0, hd, c, tag);
        m_st[b] = 2; m_vec[b] = '0; m_vec[b][c] = 1'b1;
      end else if (own == c) begin
        expect_msg(K_WACK, c, b, '0, 1'b0, c, tag);
      end else begin
        expect_msg(K_IFWD, own, b, '0, 1'b0, c, tag);
        expect_msg(K_WACK, c, b, '0, 1'b0, c, tag);
        m_vec[b] = '0; m_vec[b][c] = 1'b1;
      end
    end
  endtask

  task automatic set_req(input int c, input bit w, input int b);
    req_write[c] = w;
    req_blk[c*BW +: BW] = BW'(b);
  endtask

  task automatic go(input logic [N-1:0] mask);
    logic [N-1:0] acc;
    @(negedge clk);
    req_valid = mask;
    while (req_valid != '0) begin
      #1;
      acc = req_valid & req_ready;
      @(negedge clk);
      req_valid = req_valid & ~acc;
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || resp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic one(input int c, input bit w, input int b, input string tag);
    model(c, w, b, tag);
    set_req(c, w, b);
    go(N'(1) << c);
    drain();
  endtask

  // monitor / scoreboard and responder
  initial begin : mon
    int cyc;
    bit pv;
    msg_t pm, cur, e;
    string t;
    resp_t r;
    int pend;
    cyc = 0; pv = 1'b0; pm = '0;
    out_ready = 1'b1; ack_valid = 1'b0; wb_valid = 1'b0;
    ack_core = '0; ack_blk = '0; wb_core = '0; wb_blk = '0; wb_data = '0;
    forever begin
      @(negedge clk);
      cyc++;
      ack_valid = 1'b0; wb_valid = 1'b0;
      if (resp_q.size() > 0 && resp_q[0].due <= cyc) begin
        r = resp_q.pop_front();
        if (r.isack) begin ack_valid = 1'b1; ack_core = r.c; ack_blk = r.b; end
        else begin wb_valid = 1'b1; wb_core = r.c; wb_blk = r.b; wb_data = wbval(r.b, r.c); end
      end
      out_ready = bp ? (cyc % 3 != 0) : 1'b1;
      #1;
      cur = '{k: out_kind, d: out_dest, b: out_blk, dat: out_data, hd: out_has_data, rq: out_requester};
      if (pv) chk(out_valid && cur == pm, "R11", "stalled message held", 32'(cur), 32'(pm));
      pv = out_valid && !out_ready;
      pm = cur;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10", "unexpected message", 32'(cur), 32'h0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(cur == e, t, "outbound message", 32'(cur), 32'(e));
        end
        if (cur.k == K_WACK) begin
          pend = 0;
          foreach (resp_q[i]) if (resp_q[i].isack) pend++;
          chk(pend == 0, "R5", "grant before all acks", 32'(pend), 32'h0);
        end
        if (cur.k == K_INV || cur.k == K_IFWD)
          resp_q.push_back('{isack: 1'b1, c: cur.d, b: cur.b, due: cyc + 3});
        else if (cur.k == K_FRD)
          resp_q.push_back('{isack: 1'b0, c: cur.d, b: cur.b, due: cyc + 2});
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    for (int b = 0; b < NB; b++) begin
      m_st[b] = 0; m_vec[b] = '0; m_mem[b] = DW'(32 + 3 * b);
    end
    rst_n = 1'b0; req_valid = '0; req_write = '0; req_blk = '0;
    repeat (3) @(negedge clk);
    #2;
    chk(out_valid == 1'b0, "R1", "out_valid in reset", 32'(out_valid), 0);
    chk(req_ready == '0, "R9", "ready with no valid", 32'(req_ready), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    one(0, 1'b0, 1, "R2");        // read Uncached
    one(2, 1'b0, 1, "R3");        // read Shared, add sharer
    one(3, 1'b1, 1, "R5");        // non-sharer write: inv 0,2 + grant with data
    one(1, 1'b0, 1, "R4");        // read Modified: forward to 3, write-back
    one(0, 1'b0, 1, "R4");        // served with repaired memory
    one(1, 1'b1, 1, "R6");        // upgrade: inv 0,3 only, no payload
    one(1, 1'b1, 1, "R8");        // owner rewrite, immediate grant
    one(2, 1'b1, 1, "R7");        // ownership moves 1 -> 2
    one(3, 1'b0, 1, "R4");        // memory stale until write-back from 2
    one(3, 1'b1, 6, "R6");        // write to Uncached carries data

    // same-cycle reads, lowest core first
    model(0, 1'b0, 5, "R9"); model(1, 1'b0, 5, "R9");
    set_req(0, 1'b0, 5); set_req(1, 1'b0, 5);
    go(4'b0011); drain();

    // racing writers on a Shared block
    model(0, 1'b1, 5, "R10"); model(1, 1'b1, 5, "R10");
    set_req(0, 1'b1, 5); set_req(1, 1'b1, 5);
    go(4'b0011); drain();
    one(2, 1'b0, 5, "R10");       // later writer 1 owns: forward to 1

    // burst from all cores under back-pressure
    bp = 1'b1;
    model(0, 1'b0, 0, "R10"); model(1, 1'b1, 2, "R10");
    model(2, 1'b0, 2, "R10"); model(3, 1'b1, 0, "R10");
    set_req(0, 1'b0, 0); set_req(1, 1'b1, 2); set_req(2, 1'b0, 2); set_req(3, 1'b1, 0);
    go(4'b1111); drain();
    one(2, 1'b1, 1, "R11");
    bp = 1'b0;

    chk(exp_q.size() == 0, "R10", "leftover expected messages", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule